// File: doc/BRIEF.md
# SPI Transaction Sequencer with Receive Skip

This block runs one SPI master transaction from a single 32-bit command word. The command names a target chip select, a byte count of up to 65536, a transmit-only flag, a receive-skip count and a dual-line input flag. Chip select stays asserted from the first bit to the last. Transmit bytes come from a 32-byte transmit FIFO that is inside the block. Received bytes leave the block as one-cycle pushes toward a receive FIFO outside it.

The receive-skip count is meant for reads of the form "opcode plus address, then data". The leading bytes go out on MOSI from the FIFO, and the bytes that arrive during them are discarded. After the skip bytes the block can change to dual-line input, which collects two bits per SCLK. During the read phase the block does not wait for transmit data. It sends zeros when the FIFO is empty.

The bus is SPI mode 0. SCLK idles low, input is sampled on the rising edge, MOSI changes after the falling edge, and bytes go MSB first. SCLK runs at half the core clock. A global enable can freeze the sequencer at any point.

Top module: `spi_seq_top`

## Requirements
- R1: Command bits 31:30 select the chip select. Only `cs_n_o[sel]` goes low, and it stays low, unchanged, from command acceptance to the end of the transaction. All chip selects are high while idle.
- R2: Command bits 15:0 hold the byte count minus one. Exactly that many bytes plus one are shifted in mode 0, MSB first. MOSI carries the bytes in the order they were taken from the FIFO.
- R3: Command bits 23:16 give the skip count S. Data received during the first S bytes is never pushed. The remaining count minus S bytes are pushed in order on `rx_valid_o`/`rx_data_o`. Nothing is pushed when S is at least the byte count.
- R4: With command bit 27 (transmit-only) set, no byte is pushed.
- R5: With command bit 28 (dual) set and S nonzero, each byte after the skip takes four SCLK periods. Two bits are taken per rising edge, `sdi_i[1]` being the more significant, and `mosi_oe_o` is low for those bytes. With S zero the dual bit has no effect.
- R6: The transmit FIFO holds 32 bytes. Write size 0 stores `data[7:0]`. Size 1 stores `data[15:8]` and then `data[7:0]`. Size 2 or 3 stores `data[31:24]` first, down to `data[7:0]`. A write that does not fit is discarded as a whole.
- R7: During skip bytes, and in every byte of a transaction with S zero, an empty FIFO holds SCLK low until data arrives. A single-line byte after a nonzero skip takes FIFO data if there is some, and otherwise sends 0x00 without waiting.
- R8: `done_o` pulses for one cycle, in the cycle after the last falling SCLK edge. In that cycle `busy_o` is already low.
- R9: A command presented while a transaction is active is ignored.
- R10: While `enable_i` is low, commands are ignored. An active transaction also freezes, with SCLK and chip select held, and continues unchanged once `enable_i` returns high.
- R11: After reset all chip selects are high, SCLK is low, `busy_o` and `done_o` are low and `mosi_oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Global enable; low freezes the sequencer |
| cmd_i | input | 32 | Command word |
| cmd_valid_i | input | 1 | Command strobe |
| tx_wr_i | input | 1 | Transmit FIFO write strobe |
| tx_size_i | input | 2 | Write size: 0 byte, 1 halfword, 2/3 word |
| tx_data_i | input | 32 | Transmit write data, big-endian lanes |
| sdi_i | input | 2 | Serial input; bit 0 in single mode, both in dual mode |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial output |
| mosi_oe_o | output | 1 | MOSI output enable, low during dual input bytes |
| cs_n_o | output | 4 | Active-low chip selects |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Push strobe for rx_data_o |
| busy_o | output | 1 | Transaction active |
| done_o | output | 1 | End-of-transaction pulse |

## Verification
A byte counter or skip counter with the wrong value shows at the ports within the same transaction. The push count differs from count minus skip, or `done_o` arrives one byte period (17 or 9 cycles) early or late. A bad phase flag shows within one byte period, as a wrong number of SCLK edges per byte or a MOSI that sends zeros where FIFO data was due. A FIFO pointer or count error shows in the next transaction that reads the FIFO, as misordered or stray bytes on MOSI. The bench acts as a bit-level slave and compares every MOSI byte and every pushed byte against values computed from the command fields.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef struct packed {
    logic [1:0]  cs;
    logic        dual;
    logic        tx_only;
    logic [7:0]  skip;
    logic [15:0] len_m1;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.cs      = w[31:30];
    c.dual    = w[28];
    c.tx_only = w[27];
    c.skip    = w[23:16];
    c.len_m1  = w[15:0];
    return c;
  endfunction

endpackage

// File: rtl/spi_seq_txfifo.sv
module spi_seq_txfifo #(
  parameter int DEPTH = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_size_i,
  input  logic [31:0] wr_data_i,
  input  logic        pop_i,
  output logic [7:0]  rd_data_o,
  output logic        empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [2:0]    n_wr;
  logic          fits, wr_ok, pop_ok;
  logic [7:0]    lane [4];

  always_comb begin
    unique case (wr_size_i)
      2'd0:    n_wr = 3'd1;
      2'd1:    n_wr = 3'd2;
      default: n_wr = 3'd4;
    endcase
  end

  // big-endian: lane 0 is the most significant byte of the written unit
  always_comb begin
    for (int k = 0; k < 4; k++)
      lane[k] = wr_data_i[8*((int'(n_wr) - 1 - k) & 3) +: 8];
  end

  assign fits    = ({1'b0, count_q} + (CW+1)'(n_wr)) <= (CW+1)'(DEPTH);
  assign wr_ok   = wr_en_i && fits;
  assign empty_o = (count_q == '0);
  assign pop_ok  = pop_i && !empty_o;
  assign rd_data_o = mem[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      for (int k = 0; k < 4; k++)
        if (k < int'(n_wr)) mem[wr_ptr_q + AW'(k)] <= lane[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok)  wr_ptr_q <= wr_ptr_q + AW'(n_wr);
      if (pop_ok) rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + (wr_ok ? CW'(n_wr) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         run_i,
  input  logic         dual_i,
  input  logic [1:0]   sdi_i,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         byte_done_o,
  output logic [W-1:0] rx_byte_o
);
  localparam int CW = $clog2(W);

  logic          sclk_q;
  logic [W-1:0]  tx_sr_q, rx_sr_q;
  logic [CW-1:0] bit_cnt_q;
  logic          last;

  assign last        = dual_i ? (bit_cnt_q == CW'(W/2 - 1)) : (bit_cnt_q == CW'(W - 1));
  assign byte_done_o = sclk_q && last;
  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_sr_q[W-1];
  assign rx_byte_o   = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      bit_cnt_q <= '0;
    end else if (load_i) begin
      sclk_q    <= 1'b0;
      tx_sr_q   <= load_data_i;
      bit_cnt_q <= '0;
    end else if (run_i) begin
      if (!sclk_q) begin
        sclk_q  <= 1'b1;
        rx_sr_q <= dual_i ? {rx_sr_q[W-3:0], sdi_i} : {rx_sr_q[W-2:0], sdi_i[0]};
      end else begin
        sclk_q    <= 1'b0;
        tx_sr_q   <= {tx_sr_q[W-2:0], 1'b0};
        bit_cnt_q <= bit_cnt_q + CW'(1);
      end
    end
  end

  a_r2_load_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !sclk_o);

  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(sclk_o) && $stable(mosi_o));

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int MAX_LEN = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [31:0]       cmd_i,
  input  logic              cmd_valid_i,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  output logic              fifo_pop_o,
  output logic              load_o,
  output logic [7:0]        load_data_o,
  output logic              dual_o,
  output logic              run_o,
  input  logic              byte_done_i,
  output logic              store_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              mosi_oe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  seq_state_e       state_q;
  logic [1:0]       cs_q;
  logic [LEN_W-1:0] left_q;
  logic [7:0]       skip_q;
  logic             has_skip_q, dual_en_q, tx_only_q;
  logic             cur_dual_q, cur_store_q, done_q;

  cmd_t c;
  logic in_skip, dual_byte, need_data, can_load, accept, byte_end, last_byte;

  assign c         = decode_cmd(cmd_i);
  assign in_skip   = (skip_q != 8'd0);
  assign dual_byte = !in_skip && dual_en_q;
  assign need_data = in_skip || !has_skip_q;
  assign can_load  = (state_q == ST_LOAD) && enable_i &&
                     (dual_byte || !fifo_empty_i || !need_data);
  assign fifo_pop_o  = can_load && !dual_byte && !fifo_empty_i;
  assign load_o      = can_load;
  assign load_data_o = fifo_pop_o ? fifo_data_i : 8'h00;
  assign run_o       = enable_i && (state_q == ST_SHIFT);
  assign byte_end    = run_o && byte_done_i;
  assign store_o     = byte_end && cur_store_q;
  assign last_byte   = (left_q == LEN_W'(1));
  assign accept      = (state_q == ST_IDLE) && enable_i && cmd_valid_i;
  assign dual_o      = cur_dual_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign mosi_oe_o   = !(busy_o && cur_dual_q);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !(busy_o && (cs_q == 2'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cs_q        <= '0;
      left_q      <= '0;
      skip_q      <= '0;
      has_skip_q  <= 1'b0;
      dual_en_q   <= 1'b0;
      tx_only_q   <= 1'b0;
      cur_dual_q  <= 1'b0;
      cur_store_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cs_q       <= c.cs;
          left_q     <= LEN_W'(c.len_m1) + LEN_W'(1);
          skip_q     <= c.skip;
          has_skip_q <= (c.skip != 8'd0);
          dual_en_q  <= c.dual && (c.skip != 8'd0);
          tx_only_q  <= c.tx_only;
          cur_dual_q <= 1'b0;
          state_q    <= ST_LOAD;
        end
        ST_LOAD: if (can_load) begin
          cur_dual_q  <= dual_byte;
          cur_store_q <= !in_skip && !tx_only_q;
          if (in_skip) skip_q <= skip_q - 8'd1;
          state_q     <= ST_SHIFT;
        end
        ST_SHIFT: if (byte_end) begin
          left_q <= left_q - LEN_W'(1);
          if (last_byte) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  a_r1_select_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cs_n_o));

  a_r4_no_push_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> !tx_only_q);

  a_r8_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !enable_i) |=> !busy_o);

endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top #(
  parameter int NUM_CS     = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int MAX_LEN    = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [31:0]       cmd_i,
  input  logic              cmd_valid_i,
  input  logic              tx_wr_i,
  input  logic [1:0]        tx_size_i,
  input  logic [31:0]       tx_data_i,
  input  logic [1:0]        sdi_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  logic       fifo_pop, fifo_empty;
  logic [7:0] fifo_data, load_data;
  logic       load, run, dual, byte_done;

  spi_seq_txfifo #(.DEPTH(FIFO_DEPTH)) u_txfifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (tx_wr_i),
    .wr_size_i (tx_size_i),
    .wr_data_i (tx_data_i),
    .pop_i     (fifo_pop),
    .rd_data_o (fifo_data),
    .empty_o   (fifo_empty)
  );

  spi_seq_ctrl #(.NUM_CS(NUM_CS), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .cmd_i        (cmd_i),
    .cmd_valid_i  (cmd_valid_i),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .fifo_pop_o   (fifo_pop),
    .load_o       (load),
    .load_data_o  (load_data),
    .dual_o       (dual),
    .run_o        (run),
    .byte_done_i  (byte_done),
    .store_o      (rx_valid_o),
    .cs_n_o       (cs_n_o),
    .mosi_oe_o    (mosi_oe_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  spi_seq_shifter #(.W(8)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (load_data),
    .run_i       (run),
    .dual_i      (dual),
    .sdi_i       (sdi_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_data_o)
  );

endmodule

// File: tb/spi_seq_top_tb.sv
`timescale 1ns/1ps
module spi_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [31:0] cmd = '0;
  logic        cmd_v = 1'b0;
  logic        tx_wr = 1'b0;
  logic [1:0]  tx_size = '0;
  logic [31:0] tx_data = '0;
  logic [1:0]  sdi;
  logic        sclk, mosi, mosi_oe, rx_valid, busy, done;
  logic [3:0]  cs_n;
  logic [7:0]  rx_data;

  int checks = 0;
  int errs = 0;

  int rises = 0, base = 0;
  int rx_n = 0, rx_base = 0;
  int done_n = 0;
  int cur_skip = 0, cur_seed = 0;
  bit cur_dual = 1'b0;
  logic [7:0] rx_buf [256];
  logic [7:0] mosi_buf [64];

  always #4 clk = ~clk;

  spi_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cmd_i(cmd), .cmd_valid_i(cmd_v),
    .tx_wr_i(tx_wr), .tx_size_i(tx_size), .tx_data_i(tx_data), .sdi_i(sdi),
    .sclk_o(sclk), .mosi_o(mosi), .mosi_oe_o(mosi_oe), .cs_n_o(cs_n),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] sbyte(int k, int seed);
    return 8'((k * 29 + 8'h5A + seed) & 255);
  endfunction

  function automatic logic [7:0] fbyte(int k, int seed);
    return 8'((k * 13 + 8'h33 + seed * 3) & 255);
  endfunction

  function automatic logic [1:0] slave_bits(int n, int skip, bit dual, int seed);
    logic [7:0] b;
    int m, p;
    if (dual && n >= skip * 8) begin
      m = n - skip * 8;
      b = sbyte(skip + m / 4, seed);
      p = 3 - (m % 4);
      return {b[2*p+1], b[2*p]};
    end
    b = sbyte(n / 8, seed);
    return {1'b0, b[7 - (n % 8)]};
  endfunction

  always @(rises or base or cur_skip or cur_dual or cur_seed)
    sdi = slave_bits(rises - base, cur_skip, cur_dual, cur_seed);

  always @(posedge sclk) begin
    int n;
    n = rises - base;
    if (!(cur_dual && n >= cur_skip * 8) && n < 512)
      mosi_buf[n / 8][7 - (n % 8)] = mosi;
    rises = rises + 1;
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_buf[rx_n % 256] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (done) done_n <= done_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_fifo(input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    tx_wr = 1'b1; tx_size = sz; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    int k = 0;
    while (k < n) begin
      if (n - k >= 4) begin
        wr_fifo(2'd2, {fbyte(k, seed), fbyte(k+1, seed), fbyte(k+2, seed), fbyte(k+3, seed)});
        k += 4;
      end else if (n - k >= 2) begin
        wr_fifo(2'd1, {16'h0, fbyte(k, seed), fbyte(k+1, seed)});
        k += 2;
      end else begin
        wr_fifo(2'd0, {24'h0, fbyte(k, seed)});
        k += 1;
      end
    end
  endtask

  task automatic pulse_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd = w; cmd_v = 1'b1;
    @(negedge clk);
    cmd_v = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(int cs, bit dual, bit txo, int skip, int len);
    return {2'(cs), 1'b0, dual, txo, 3'b0, 8'(skip), 16'(len - 1)};
  endfunction

  task automatic start_txn(input int cs, input bit dual, input bit txo, input int skip,
                           input int len, input int seed);
    for (int i = 0; i < 64; i++) mosi_buf[i] = 8'hxx;
    base = rises;
    rx_base = rx_n;
    cur_skip = skip; cur_dual = dual && (skip != 0); cur_seed = seed;
    pulse_cmd(mk_cmd(cs, dual, txo, skip, len));
  endtask

  task automatic finish_txn(input int cs, input bit txo, input int skip, input int len,
                            input int nfifo, input int seed);
    int d0 = done_n;
    int cs_bad = 0;
    int t = 0;
    int exp_rx, nsingle, got;
    bit seen = 1'b0;
    while (!seen && t < 6000) begin
      @(negedge clk);
      t++;
      if (busy && cs_n != ~(4'b1 << cs)) cs_bad++;
      if (done) begin
        seen = 1'b1;
        chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
      end
    end
    chk(seen, "R8 done pulse seen", int'(seen), 1);
    chk(cs_bad == 0, "R1 chip select during transaction", cs_bad, 0);
    repeat (3) @(negedge clk);
    chk(done_n - d0 == 1, "R8 single done pulse", done_n - d0, 1);
    chk(cs_n == 4'hF, "R1 all deselected when idle", int'(cs_n), 15);
    exp_rx = txo ? 0 : (len > skip ? len - skip : 0);
    got = rx_n - rx_base;
    chk(got == exp_rx, txo ? "R4 push count" : "R3 push count", got, exp_rx);
    for (int j = 0; j < exp_rx && j < got; j++)
      chk(rx_buf[(rx_base + j) % 256] == sbyte(skip + j, seed),
          cur_dual ? "R5 dual byte" : "R3 received byte",
          int'(rx_buf[(rx_base + j) % 256]), int'(sbyte(skip + j, seed)));
    nsingle = cur_dual ? (skip < len ? skip : len) : len;
    for (int k = 0; k < nsingle; k++)
      chk(mosi_buf[k] === (k < nfifo ? fbyte(k, seed) : 8'h00), "R2/R7 mosi byte",
          int'(mosi_buf[k]), int'(k < nfifo ? fbyte(k, seed) : 8'h00));
    chk(rises - base == nsingle * 8 + (len - nsingle) * 4, "R2 R5 sclk count",
        rises - base, nsingle * 8 + (len - nsingle) * 4);
  endtask

  task automatic run_txn(input int cs, input bit dual, input bit txo, input int skip,
                         input int len, input int nfifo, input int seed);
    fill(nfifo, seed);
    start_txn(cs, dual, txo, skip, len, seed);
    finish_txn(cs, txo, skip, len, nfifo, seed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int lens [3] = '{1, 3, 6};
    int skips [4] = '{0, 1, 2, 7};
    int seed = 1;
    int r0, nf;
    logic [3:0] cs0;
    logic sclk0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 4'hF, "R11 cs reset", int'(cs_n), 15);
    chk(sclk == 1'b0, "R11 sclk reset", int'(sclk), 0);
    chk(busy == 1'b0 && done == 1'b0, "R11 busy/done reset", int'({busy, done}), 0);
    chk(mosi_oe == 1'b1, "R11 oe reset", int'(mosi_oe), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: length, skip, dual, transmit-only, chip select
    foreach (lens[a]) foreach (skips[b]) for (int dv = 0; dv < 2; dv++)
      for (int tv = 0; tv < 2; tv++) begin
        if (skips[b] == 0) nf = lens[a];
        else if (dv == 1) nf = (skips[b] < lens[a]) ? skips[b] : lens[a];
        else nf = seed[0] ? lens[a] : ((skips[b] < lens[a]) ? skips[b] : lens[a]);
        run_txn(seed % 4, bit'(dv), bit'(tv), skips[b], lens[a], nf, seed);
        seed++;
      end

    // R6: full FIFO, overflow write dropped, read phase sends zeros (R7)
    for (int i = 0; i < 8; i++)
      wr_fifo(2'd2, {fbyte(4*i, 99), fbyte(4*i+1, 99), fbyte(4*i+2, 99), fbyte(4*i+3, 99)});
    wr_fifo(2'd1, 32'h0000EEEE);
    start_txn(3, 1'b0, 1'b1, 32, 34, 99);
    finish_txn(3, 1'b1, 32, 34, 32, 99);

    // R7: no-skip transaction stalls on an empty FIFO
    start_txn(2, 1'b0, 1'b0, 0, 2, 7);
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R7 waiting while empty", int'(busy), 1);
    chk(rises == base && sclk == 1'b0, "R7 no clock while empty", rises - base, 0);
    fill(2, 7);
    finish_txn(2, 1'b0, 0, 2, 2, 7);

    // R10: freeze mid-transaction
    fill(4, 11);
    start_txn(1, 1'b0, 1'b0, 0, 4, 11);
    repeat (25) @(negedge clk);
    en = 1'b0;
    r0 = rises; cs0 = cs_n; sclk0 = sclk;
    repeat (20) @(negedge clk);
    chk(rises == r0 && sclk == sclk0, "R10 sclk frozen", rises - r0, 0);
    chk(cs_n == cs0 && busy == 1'b1, "R10 cs held", int'(cs_n), int'(cs0));
    en = 1'b1;
    finish_txn(1, 1'b0, 0, 4, 4, 11);

    // R10: command while disabled is ignored
    en = 1'b0;
    pulse_cmd(mk_cmd(0, 1'b0, 1'b1, 0, 1));
    repeat (5) @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 4'hF, "R10 command ignored when disabled", int'(busy), 0);

    // R9: command during an active transaction is ignored
    fill(3, 21);
    start_txn(1, 1'b0, 1'b0, 0, 3, 21);
    repeat (10) @(negedge clk);
    pulse_cmd(mk_cmd(2, 1'b0, 1'b1, 0, 5));
    finish_txn(1, 1'b0, 0, 3, 3, 21);
    r0 = done_n;
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && done_n == r0, "R9 second command dropped", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule